// File: doc/BRIEF.md
# Dual Glitchless Clock Divider

This block derives two divided clocks from one source clock. Each of two independent dividers takes its ratio from the upper three bits of its own configuration byte. Output 0 always carries the first divider. Output 1 carries either the first or the second divider, chosen by a select input. Each output is modelled as a logic level plus a tri-state enable. Each output has its own enable, and a shared force-low input pulls every enabled output to logic low.

The design runs on a core clock `clk` at twice the source-clock rate, so one source cycle is two `clk` cycles. The source phase is the low bit of that timing. A divider programmed for ratio N therefore has a period of 2N `clk` cycles.

A ratio change never makes a runt pulse. The divider finishes its current period and then holds low. Both dividers restart together, which keeps their rising edges aligned at every common multiple of their periods.

Top module: `gdiv_dual_out`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, both levels and both output enables are 0 after that edge. The first edge with `rst` low starts both dividers at the start of a high phase.
- R2: The ratio code in bits 7:5 of a configuration byte selects N as follows: 000 gives 1, 001 gives 2, 010 gives 3, 011 gives 4, 100 gives 5, 101 gives 6, 110 gives 8 and 111 gives 16. The output period is 2N `clk` cycles.
- R3: Each period starts with a high phase. For N = 1 and for even N the high phase lasts N `clk` cycles. For odd N above 1 it lasts N-1 `clk` cycles, which is floor(N/2) source cycles.
- R4: Bits 4:0 of a configuration byte have no effect on either output.
- R5: When the ratio code changes, the divider completes its current period and then drives low. It starts its new ratio with a high phase only at the next joint restart.
- R6: A joint restart happens only when each divider is at the last cycle of its period or is holding. At a joint restart both dividers begin a new period together and load their current codes. A divider whose code did not change keeps an unbroken waveform.
- R7: Output 0 always shows the first divider. Output 1 shows the first divider when `out1_sel` is 0 and the second divider when it is 1.
- R8: When `force_low` is 1, every enabled output level is 0.
- R9: When an output's enable bit is 0, its output enable is 0 and its level is 0, whatever `force_low` is.
- R10: Every output is registered. The select, enable and force-low inputs take effect on the level and the output enable one `clk` edge after they are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the source-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| div0_cfg | input | 8 | Configuration byte for the first divider (ratio code in bits 7:5) |
| div1_cfg | input | 8 | Configuration byte for the second divider (ratio code in bits 7:5) |
| out1_sel | input | 1 | Source of output 1: 0 selects the first divider, 1 selects the second |
| out_en | input | 2 | Per-output enable; bit i belongs to output i |
| force_low | input | 1 | Drives every enabled output low |
| clk_out0 | output | 1 | Level of output 0 |
| clk_oe0 | output | 1 | Drive enable of output 0 (0 means high impedance) |
| clk_out1 | output | 1 | Level of output 1 |
| clk_oe1 | output | 1 | Drive enable of output 1 (0 means high impedance) |

## Verification
The two dividers are first run through every ratio code in complementary pairs, which separates period and duty errors for odd, even and pass-through ratios. The first divider's code is then flipped mid-period while the second divider runs its longest ratio. This shows whether the current period is truncated and whether the hold lasts until the joint restart, rather than ending at the divider's own period end. Other patterns toggle only the low configuration bits, flip the select every few cycles, and sweep every combination of enable and force-low cycle by cycle. Together they expose wrong source routing, a force-low that overrides a disable, and an extra or missing output register.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;
  localparam int CFG_W     = 8;
  localparam int CODE_W    = 3;
  localparam int CODE_LSB  = CFG_W - CODE_W;
  localparam int MAX_RATIO = 16;
  localparam int CNT_W     = $clog2(2 * MAX_RATIO);
  localparam int N_OUT     = 2;

  typedef logic [CNT_W:0] cnt_t;

  function automatic cnt_t ratio_of(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    ratio_of = cnt_t'(1);
      3'd1:    ratio_of = cnt_t'(2);
      3'd2:    ratio_of = cnt_t'(3);
      3'd3:    ratio_of = cnt_t'(4);
      3'd4:    ratio_of = cnt_t'(5);
      3'd5:    ratio_of = cnt_t'(6);
      3'd6:    ratio_of = cnt_t'(8);
      default: ratio_of = cnt_t'(MAX_RATIO);
    endcase
  endfunction
endpackage

// File: rtl/gdiv_ratio_ctr.sv
module gdiv_ratio_ctr
  import gdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic              restart_i,
  output logic              ready_o,
  output logic              lvl_o
);
  logic [CODE_W-1:0] code_q;
  cnt_t              cnt_q;
  logic              hold_q;
  cnt_t              ratio, period, high_len;
  logic              end_p;

  assign ratio    = ratio_of(code_q);
  assign period   = ratio << 1;
  assign high_len = (ratio == cnt_t'(1)) ? cnt_t'(1) : {ratio[CNT_W:1], 1'b0};
  assign end_p    = (cnt_q == period - cnt_t'(1));
  assign ready_o  = hold_q | end_p;
  assign lvl_o    = !hold_q && (cnt_q < high_len);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
      code_q <= code_i;
    end else if (!hold_q) begin
      if (end_p) begin
        if (code_i != code_q) hold_q <= 1'b1;
        else                  cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + cnt_t'(1);
      end
    end
  end

  // R5: a holding divider waits, frozen, for the joint restart
  a_r5_hold_waits: assert property (@(posedge clk) disable iff (rst)
    hold_q && !restart_i |=> hold_q && $stable(cnt_q));

  // R6: a joint restart begins a fresh period with a high phase
  a_r6_restart_fresh: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !hold_q && lvl_o);

  // R5: leaving hold happens only through a joint restart
  a_r5_hold_exit: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> $past(restart_i));
endmodule

// File: rtl/gdiv_out_stage.sv
module gdiv_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic lvl_a,
  input  logic lvl_b,
  input  logic pick_b,
  input  logic en,
  input  logic force_low,
  output logic lvl_o,
  output logic oe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      lvl_o <= en && !force_low && (pick_b ? lvl_b : lvl_a);
      oe_o  <= en;
    end
  end

  // R9: disable wins over everything, level parked low
  a_r9_disable_wins: assert property (@(posedge clk) disable iff (rst)
    !en |=> !oe_o && !lvl_o);

  // R8: force-low reaches the registered level one edge later
  a_r8_force_low: assert property (@(posedge clk) disable iff (rst)
    force_low |=> !lvl_o);

  // R10: output enable is the enable delayed by one edge
  a_r10_oe_latency: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> oe_o == $past(en));
endmodule

// File: rtl/gdiv_dual_out.sv
module gdiv_dual_out
  import gdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] div0_cfg,
  input  logic [CFG_W-1:0] div1_cfg,
  input  logic             out1_sel,
  input  logic [N_OUT-1:0] out_en,
  input  logic             force_low,
  output logic             clk_out0,
  output logic             clk_oe0,
  output logic             clk_out1,
  output logic             clk_oe1
);
  logic [N_OUT-1:0][CFG_W-1:0] cfg;
  logic [N_OUT-1:0]            ready, lvl, pick_b, lvl_out, oe_out;
  logic                        restart;

  assign cfg[0]    = div0_cfg;
  assign cfg[1]    = div1_cfg;
  assign restart   = &ready;
  assign pick_b[0] = 1'b0;
  assign pick_b[1] = out1_sel;

  for (genvar i = 0; i < N_OUT; i++) begin : g_div
    gdiv_ratio_ctr u_ctr (
      .clk       (clk),
      .rst       (rst),
      .code_i    (cfg[i][CFG_W-1:CODE_LSB]),
      .restart_i (restart),
      .ready_o   (ready[i]),
      .lvl_o     (lvl[i])
    );

    gdiv_out_stage u_out (
      .clk       (clk),
      .rst       (rst),
      .lvl_a     (lvl[0]),
      .lvl_b     (lvl[1]),
      .pick_b    (pick_b[i]),
      .en        (out_en[i]),
      .force_low (force_low),
      .lvl_o     (lvl_out[i]),
      .oe_o      (oe_out[i])
    );
  end

  assign clk_out0 = lvl_out[0];
  assign clk_oe0  = oe_out[0];
  assign clk_out1 = lvl_out[1];
  assign clk_oe1  = oe_out[1];

  // R7: with output 1 following the first divider and both outputs
  // enabled and not forced, the two levels match
  a_r7_shared_source: assert property (@(posedge clk) disable iff (rst)
    !out1_sel && (&out_en) && !force_low |=> clk_out0 == clk_out1);

  // R6: both dividers leave any period boundary together after a restart
  a_r6_joint_restart: assert property (@(posedge clk) disable iff (rst)
    restart |=> lvl[0] && lvl[1]);
endmodule

// File: tb/gdiv_dual_out_bench.sv
module gdiv_dual_out_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] div0_cfg, div1_cfg;
  logic       out1_sel;
  logic [1:0] out_en;
  logic       force_low;
  logic       clk_out0, clk_oe0, clk_out1, clk_oe1;

  gdiv_dual_out u_gdiv_dual_out (
    .clk(clk), .rst(rst), .div0_cfg(div0_cfg), .div1_cfg(div1_cfg),
    .out1_sel(out1_sel), .out_en(out_en), .force_low(force_low),
    .clk_out0(clk_out0), .clk_oe0(clk_oe0), .clk_out1(clk_out1), .clk_oe1(clk_oe1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] q_exp[$];
  string      q_tag[$];
  int         n_vec  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  int m_code[2], m_cnt[2];
  bit m_hold[2];

  function automatic int ratio_n(input int c);
    case (c)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 5;  5: return 6;  6: return 8;  default: return 16;
    endcase
  endfunction

  function automatic int high_len(input int n);
    if (n == 1) return 1;
    return 2 * (n / 2);
  endfunction

  // Driver: model the edge ahead, push expectation, then wait a cycle
  task automatic step(input string tag);
    logic [3:0] e;
    bit lv[2], rdy[2], rs;
    int nc[2];
    nc[0] = int'(div0_cfg[7:5]);
    nc[1] = int'(div1_cfg[7:5]);
    if (rst) begin
      e = 4'b0000;
      for (int k = 0; k < 2; k++) begin
        m_code[k] = nc[k]; m_cnt[k] = 0; m_hold[k] = 1'b0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        lv[k]  = !m_hold[k] && (m_cnt[k] < high_len(ratio_n(m_code[k])));
        rdy[k] = m_hold[k] || (m_cnt[k] == 2 * ratio_n(m_code[k]) - 1);
      end
      e[3] = out_en[0] && !force_low && lv[0];
      e[2] = out_en[0];
      e[1] = out_en[1] && !force_low && (out1_sel ? lv[1] : lv[0]);
      e[0] = out_en[1];
      rs = rdy[0] && rdy[1];
      for (int k = 0; k < 2; k++) begin
        if (rs) begin
          m_code[k] = nc[k]; m_cnt[k] = 0; m_hold[k] = 1'b0;
        end else if (!m_hold[k]) begin
          if (rdy[k]) begin
            if (nc[k] != m_code[k]) m_hold[k] = 1'b1;
            else m_cnt[k] = 0;
          end else begin
            m_cnt[k]++;
          end
        end
      end
    end
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // Monitor: compare after each rising edge, away from the edge
  always @(posedge clk) begin
    logic [3:0] got, e;
    string t;
    #2;
    if (q_exp.size() > 0 && !done) begin
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      got = {clk_out0, clk_oe0, clk_out1, clk_oe1};
      n_vec++;
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s: out0/oe0/out1/oe1 actual=%b expected=%b at %0t", t, got, e, $time);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; div0_cfg = 8'h20; div1_cfg = 8'h00;
    out1_sel = 1'b1; out_en = 2'b11; force_low = 1'b0;
    run(3, "R1");
    rst = 1'b0;
    run(40, "R1");
    // R2 R3: every code, paired so both dividers sweep all ratios
    for (int c = 0; c < 8; c++) begin
      div0_cfg = {3'(c), 5'b0};
      div1_cfg = {3'(7 - c), 5'b0};
      run(100, "R2");
    end
    div0_cfg = 8'h40; div1_cfg = 8'h80;
    run(80, "R3");
    // R4: low bits churn, ratio codes fixed
    for (int i = 0; i < 120; i++) begin
      div0_cfg[4:0] = 5'(i * 7);
      div1_cfg[4:0] = 5'(i * 13 + 3);
      step("R4");
    end
    // R5: first divider changes mid-period, second runs its longest ratio
    div1_cfg = 8'hE0;
    for (int i = 0; i < 6; i++) begin
      div0_cfg = (i % 2 == 0) ? 8'h60 : 8'h00;
      run(i * 3 + 5, "R5");
      run(70, "R5");
    end
    // R6: both change at once, then stagger
    div0_cfg = 8'hA0; div1_cfg = 8'h40;
    run(90, "R6");
    div0_cfg = 8'h20;
    run(4, "R6");
    div1_cfg = 8'hC0;
    run(90, "R6");
    // R7: output 1 source switching
    for (int i = 0; i < 16; i++) begin
      out1_sel = i[0];
      run(7, "R7");
    end
    out1_sel = 1'b1;
    // R8: force-low pulses
    for (int i = 0; i < 12; i++) begin
      force_low = i[0];
      run(5, "R8");
    end
    force_low = 1'b0;
    // R9: disables against force-low
    for (int i = 0; i < 8; i++) begin
      out_en = 2'(i);
      force_low = i[2];
      run(9, "R9");
    end
    // R10: per-cycle control changes
    for (int i = 0; i < 64; i++) begin
      out_en    = 2'(i ^ (i >> 2));
      force_low = (i % 5 == 0);
      out1_sel  = i[1];
      step("R10");
    end
    out_en = 2'b11; force_low = 1'b0;
    run(20, "R10");
    rst = 1'b1;
    run(2, "R1");
    rst = 1'b0;
    run(20, "R1");
    #(CLK_PERIOD);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule